// File: doc/BRIEF.md
# Count Event Qualifier (Prescaler and Glitch Filter)

This block turns one of four slow source clocks, each presented as a one-cycle enable strobe in the fast clock domain, into the count event that a low power timer core consumes. It has two modes. In time mode it divides the chosen strobe by a programmable power of two and emits a one-cycle tick on each wrap of its divider. In pulse mode it acts as a glitch filter on an already selected, polarity-adjusted input. A new input level is accepted only after it has held across a programmable number of strobes.

A 4-bit scale value n sets both modes. The divider ratio is 2^(n+1). The filter needs 2^n strobes, and n = 0 is treated as 1. A bypass control skips the divider or the filter, so the selected strobe or the raw input reaches the output after one register stage. Dropping the enable clears all internal counts and forces both outputs low.

Top module: `prescale_filter`

## Requirements
- R1: `src_sel_i` value k (0..3) picks `src_stb_i[k]` as the only strobe that counts. Strobes on the other three lines have no effect on either output.
- R2: In time mode without bypass, with scale n, `tick_o` is high for exactly the one cycle after every 2^(n+1)-th selected strobe since the block was enabled. It is low in every other cycle.
- R3: In time mode with bypass, `tick_o` equals the selected strobe of the previous cycle.
- R4: In pulse mode without bypass, with scale n >= 1, `level_o` takes the value of `pin_i` in the cycle after the 2^n-th selected strobe at which `pin_i` differed from `level_o`. `level_o` changes at no other time.
- R5: In pulse mode without bypass, any clock edge at which `pin_i` equals `level_o` restarts the filter count from zero, even when no strobe is present.
- R6: In pulse mode without bypass, scale 0 needs 2 strobes, the same as scale 1.
- R7: In pulse mode with bypass, `level_o` equals `pin_i` of the previous cycle.
- R8: While `enable_i` is low, both outputs are low in the following cycle. The divider and filter counts restart from zero when the block is enabled again.
- R9: `tick_o` stays low in pulse mode (`pulse_mode_i` = 1). `level_o` stays low in time mode (`pulse_mode_i` = 0).
- R10: During and right after reset, `tick_o` and `level_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Block enable; low clears all state |
| pulse_mode_i | input | 1 | 0 time mode (divider), 1 pulse mode (filter) |
| bypass_i | input | 1 | 1 skips the divider or the filter |
| src_sel_i | input | 2 | Source strobe select |
| scale_i | input | 4 | Scale value n |
| src_stb_i | input | 4 | One-cycle strobes of the four source clocks |
| pin_i | input | 1 | Input level to filter in pulse mode |
| tick_o | output | 1 | Time-mode count tick |
| level_o | output | 1 | Pulse-mode filtered level |

## Verification
Each output has exactly one register between the inputs and the port. Every result that a set of inputs produces is due in the cycle after the clock edge that samples those inputs. The driver applies each input vector at a falling edge. At the same time it enqueues the expected tick and level, tagged with the number of the next rising edge. The monitor samples two nanoseconds after each rising edge and compares only the item whose tag matches that edge. A result that comes one cycle early or late is therefore reported as a mismatch.

// File: rtl/pf_pkg.sv
package pf_pkg;
  parameter int unsigned NUM_SRC = 4;
  parameter int unsigned SCALE_W = 4;
  localparam int unsigned SEL_W  = $clog2(NUM_SRC);
  localparam int unsigned CNT_W  = 1 << SCALE_W;

  typedef logic [CNT_W-1:0] cnt_t;

  // last divider count before wrap: 2^(n+1)-1
  function automatic cnt_t div_last(input logic [SCALE_W-1:0] n);
    cnt_t ones;
    ones = '1;
    return ones >> (CNT_W - 1 - n);
  endfunction

  // last filter count before accept: 2^max(n,1)-1
  function automatic cnt_t flt_last(input logic [SCALE_W-1:0] n);
    cnt_t ones;
    logic [SCALE_W-1:0] ne;
    ones = '1;
    ne = (n == '0) ? SCALE_W'(1) : n;
    return ones >> (CNT_W - ne);
  endfunction
endpackage

// File: rtl/pf_src_sel.sv
module pf_src_sel
  import pf_pkg::*;
(
  input  logic [NUM_SRC-1:0] stb_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               stb_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = stb_i[g] && (sel_i == SEL_W'(g));
  end

  assign stb_o = |hit;
endmodule

// File: rtl/pf_divider.sv
module pf_divider
  import pf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               bypass_i,
  input  logic               stb_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               tick_o
);
  cnt_t cnt_q;
  logic tick_q;
  logic wrap;

  assign wrap = stb_i && (cnt_q >= div_last(scale_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en_i || bypass_i) begin
      cnt_q  <= '0;
      tick_q <= en_i && stb_i;
    end else begin
      tick_q <= wrap;
      if (stb_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  // R2: a tick only follows a strobe
  a_r2_tick_after_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> $past(stb_i));
  // R2: no strobe means no count movement
  a_r2_hold_no_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bypass_i && !stb_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pf_glitch_filter.sv
module pf_glitch_filter
  import pf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               bypass_i,
  input  logic               stb_i,
  input  logic               pin_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               level_o
);
  cnt_t cnt_q;
  logic level_q;
  logic accept;

  assign accept = stb_i && (pin_i != level_q) && (cnt_q >= flt_last(scale_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (bypass_i) begin
      cnt_q   <= '0;
      level_q <= pin_i;
    end else if (pin_i == level_q) begin
      cnt_q   <= '0;
    end else if (accept) begin
      cnt_q   <= '0;
      level_q <= pin_i;
    end else if (stb_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;

  // R5: agreement restarts the count
  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bypass_i && (pin_i == level_o)) |=> (cnt_q == '0));
  // R4: filtered level moves only on a strobe
  a_r4_level_needs_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bypass_i && !stb_i) |=> $stable(level_q));
endmodule

// File: rtl/prescale_filter.sv
module prescale_filter
  import pf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               pulse_mode_i,
  input  logic               bypass_i,
  input  logic [SEL_W-1:0]   src_sel_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [NUM_SRC-1:0] src_stb_i,
  input  logic               pin_i,
  output logic               tick_o,
  output logic               level_o
);
  logic sel_stb;
  logic div_en, flt_en;

  assign div_en = enable_i && !pulse_mode_i;
  assign flt_en = enable_i &&  pulse_mode_i;

  pf_src_sel u_sel (
    .stb_i (src_stb_i),
    .sel_i (src_sel_i),
    .stb_o (sel_stb)
  );

  pf_divider u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (div_en),
    .bypass_i (bypass_i),
    .stb_i    (sel_stb),
    .scale_i  (scale_i),
    .tick_o   (tick_o)
  );

  pf_glitch_filter u_flt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (flt_en),
    .bypass_i (bypass_i),
    .stb_i    (sel_stb),
    .pin_i    (pin_i),
    .scale_i  (scale_i),
    .level_o  (level_o)
  );

  a_r8_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!tick_o && !level_o));
  a_r9_no_tick_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_mode_i |=> !tick_o);
  a_r9_no_level_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_mode_i |=> !level_o);
  a_r7_bypass_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && pulse_mode_i && bypass_i) |=> (level_o == $past(pin_i)));
  a_r3_bypass_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !pulse_mode_i && bypass_i) |=> (tick_o == $past(src_stb_i[src_sel_i])));
  a_r1_tick_from_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(src_stb_i[src_sel_i]));
endmodule

// File: tb/sim_prescale_filter.sv
`timescale 1ns/1ps
module sim_prescale_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, pm = 1'b0, byp = 1'b0, pin = 1'b0;
  logic [1:0] sel = '0;
  logic [3:0] sc = '0, stb = '0;
  logic       tick, level;

  always #4 clk = ~clk;

  prescale_filter u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .pulse_mode_i(pm),
    .bypass_i(byp), .src_sel_i(sel), .scale_i(sc), .src_stb_i(stb),
    .pin_i(pin), .tick_o(tick), .level_o(level)
  );

  typedef struct {
    int    cyc;
    logic  t;
    logic  l;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0, n_chk = 0, n_fail = 0;
  bit   done = 0;

  // model state
  int   mc = 0, mf = 0;
  logic ml = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic step(input logic [3:0] s, input logic p, input string tag);
    logic et, el, ss;
    int lim, need;
    exp_t e;
    stb = s; pin = p;
    ss   = s[sel];
    lim  = 1 << (sc + 1);
    need = 1 << ((sc == 0) ? 1 : sc);
    et = 0; el = 0;
    if (!en) begin
      mc = 0; mf = 0; ml = 0;
    end else if (!pm) begin
      mf = 0; ml = 0;
      if (byp) begin et = ss; mc = 0; end
      else if (ss) begin
        if (mc == lim - 1) begin et = 1; mc = 0; end else mc++;
      end
    end else begin
      mc = 0;
      if (byp) begin ml = p; mf = 0; end
      else if (p == ml) mf = 0;
      else if (ss) begin
        mf++;
        if (mf == need) begin ml = p; mf = 0; end
      end
      el = ml;
    end
    e.cyc = cyc + 1; e.t = et; e.l = el; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic off();
    en = 0;
    step(4'b0000, 1'b0, "R8");
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      if (q.size() > 0 && q[0].cyc == cyc) begin
        e = q.pop_front();
        n_chk++;
        if (tick !== e.t || level !== e.l) begin
          n_fail++;
          $display("FAIL %s cyc %0d: tick=%b level=%b expected tick=%b level=%b",
                   e.tag, cyc, tick, level, e.t, e.l);
        end
      end
    end
  end

  // driver
  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs low in reset
    n_chk++;
    if (tick !== 1'b0 || level !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 in reset: tick=%b level=%b expected 0 0", tick, level);
    end
    rst_n = 1'b1;
    step(4'b0000, 1'b0, "R10");

    // R2: divider for n = 0..3, strobe every other cycle
    for (int n = 0; n < 4; n++) begin
      off();
      en = 1; pm = 0; byp = 0; sel = 0; sc = 4'(n);
      for (int i = 0; i < 40; i++) step((i % 2 == 0) ? 4'b0001 : 4'b0000, 1'b0, "R2");
    end

    // R1: unselected strobes ignored, then other selects
    off();
    en = 1; sc = 4'd1; sel = 0;
    for (int i = 0; i < 24; i++) step((i % 2 == 0) ? 4'b0001 : 4'b1110, 1'b0, "R1");
    for (int k = 1; k < 4; k++) begin
      off();
      en = 1; sel = 2'(k); sc = 4'd0;
      for (int i = 0; i < 24; i++) begin
        lfsr = nxt(lfsr);
        step(lfsr[3:0], 1'b0, "R1");
      end
    end

    // R3: bypass in time mode
    off();
    en = 1; byp = 1; sel = 3; sc = 4'd5;
    for (int i = 0; i < 30; i++) begin
      lfsr = nxt(lfsr);
      step(lfsr[7:4], 1'b0, "R3");
    end
    byp = 0;

    // R4 / R5: filter with n = 2 (4 strobes)
    off();
    en = 1; pm = 1; sel = 1; sc = 4'd2;
    for (int i = 0; i < 3; i++) step(4'b0010, 1'b1, "R4");
    step(4'b0000, 1'b0, "R5");                          // restart without strobe
    for (int i = 0; i < 3; i++) step(4'b0010, 1'b1, "R5");
    step(4'b1101, 1'b1, "R1");                          // unselected strobes only
    step(4'b0010, 1'b1, "R4");                          // 4th strobe -> level 1
    step(4'b0000, 1'b1, "R4");
    for (int i = 0; i < 8; i++) step((i % 3 == 0) ? 4'b0010 : 4'b0000, 1'b0, "R4");

    // R6: scale 0 behaves like scale 1
    off();
    en = 1; pm = 1; sc = 4'd0;
    step(4'b0010, 1'b1, "R6");
    step(4'b0010, 1'b1, "R6");
    step(4'b0010, 1'b0, "R6");
    step(4'b0010, 1'b0, "R6");
    step(4'b0000, 1'b0, "R6");

    // R4 random pin with filter n = 1
    sc = 4'd1;
    for (int i = 0; i < 60; i++) begin
      lfsr = nxt(lfsr);
      step({2'b00, lfsr[0], 1'b0}, lfsr[5], "R4");
    end

    // R7: bypass in pulse mode
    byp = 1;
    for (int i = 0; i < 20; i++) begin
      lfsr = nxt(lfsr);
      step(4'b0000, lfsr[2], "R7");
    end
    byp = 0;

    // R8: disable mid-count, then recount from zero
    off();
    en = 1; pm = 0; sel = 0; sc = 4'd1;
    for (int i = 0; i < 3; i++) step(4'b0001, 1'b0, "R8");
    off();
    en = 1;
    for (int i = 0; i < 5; i++) step(4'b0001, 1'b0, "R8");
    off();
    en = 1; pm = 1; sc = 4'd1; sel = 0;
    step(4'b0001, 1'b1, "R8");
    step(4'b0001, 1'b1, "R8");
    step(4'b0000, 1'b1, "R8");
    en = 0;
    step(4'b0001, 1'b1, "R8");
    en = 1;
    step(4'b0001, 1'b1, "R8");
    step(4'b0000, 1'b1, "R8");

    // R9: mode switch leaves the other output low
    pm = 0;
    for (int i = 0; i < 6; i++) step(4'b0001, 1'b1, "R9");

    off();
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule